// File: doc/BRIEF.md
# Page-Table Address Translation Unit

This block turns a 14-bit virtual address into a 12-bit physical address by way of a single-level page table kept in internal storage. Pages are 64 bytes, so the low six address bits are the page offset and the upper eight form the virtual page number. The page number is added to a page-table base register to select a table slot. Each slot holds a valid flag, a user-access flag, a read-permission flag, a write-permission flag and a physical page number.

A request carries the address, a write flag and a user-mode flag. One cycle later the unit answers with a strobed response. The response holds either the translated address or a fault kind, and the fault kind tells a missing page apart from an access-rights violation. Software loads table slots and the base register through a separate write port. That port is honoured only while the lookup path is idle.

Top module: `pt_xlate`

## Requirements
- R1: Every cycle with `reqValid` high produces exactly one cycle of `rspValid` high on the following cycle. A cycle without a request produces no response. Back-to-back requests give back-to-back responses.
- R2: On a successful lookup, `rspPaddr` is the slot's physical page number in bits 11:6, followed by the request's offset bits 5:0 unchanged. `rspFault` is 0 and `rspKind` is 0 (none).
- R3: The slot looked up is base register + virtual page number (`reqVaddr[13:6]`). A slot word has valid in bit 9, user-allowed in bit 8, read-allowed in bit 7, write-allowed in bit 6 and the physical page number in bits 5:0.
- R4: A slot with valid = 0, or a sum base + page number of 64 or more (beyond the 64-slot table), gives a page fault. This shows as `rspFault` = 1 and `rspKind` = 1, with `rspPaddr` = 0.
- R5: A user-mode request to a slot whose user-allowed bit is 0 gives a protection fault. This shows as `rspFault` = 1 and `rspKind` = 2, with `rspPaddr` = 0. Kernel-mode requests ignore the user-allowed bit.
- R6: A write to a slot without write-allowed, or a read from a slot without read-allowed, gives a protection fault (`rspKind` = 2) in either mode.
- R7: When a slot would give both a page fault and a protection fault, the page fault is reported.
- R8: Slot writes and base-register writes are ignored in any cycle where `reqValid` is high or `rspValid` is high.
- R9: After reset, `rspValid` is 0, every slot is invalid and the base register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request strobe |
| reqVaddr | input | 14 | Virtual address |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqUser | input | 1 | 1 = user mode, 0 = kernel mode |
| rspValid | output | 1 | Response strobe, one cycle after a request |
| rspPaddr | output | 12 | Physical address, 0 on a fault |
| rspFault | output | 1 | Any fault |
| rspKind | output | 2 | 0 none, 1 page fault, 2 protection fault |
| tblWrEn | input | 1 | Slot write strobe |
| tblWrIdx | input | 6 | Slot to write |
| tblWrData | input | 10 | Slot word |
| baseWrEn | input | 1 | Base register write strobe |
| baseWrData | input | 6 | New base value |

## Verification
The assertions assume the request flags are stable and defined in any cycle where `reqValid` is high. They also assume the response offset can be traced to the address sampled one edge earlier. The stimulus therefore drives all inputs on the falling clock edge and never issues a write together with a request, except where R8 is being tested on purpose. The slot layout is loaded before any lookup. The base register is moved only in idle cycles, so every expected address follows from the requirement encodings alone.

// File: rtl/pt_xlate_pkg.sv
package pt_xlate_pkg;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_PAGE = 2'd1,
    KIND_PROT = 2'd2
  } faultKindE;

  typedef struct packed {
    logic lookup;
    logic tblWe;
    logic baseWe;
  } ctrlStrobeS;

endpackage

// File: rtl/pt_xlate_ctrl.sv
module pt_xlate_ctrl
  import pt_xlate_pkg::*;
(
  input  logic       reqValid,
  input  logic       rspPend,
  input  logic       tblWrEn,
  input  logic       baseWrEn,
  output ctrlStrobeS strobe
);

  logic busy;

  always_comb begin
    busy          = reqValid | rspPend;
    strobe.lookup = reqValid;
    strobe.tblWe  = tblWrEn & ~busy;
    strobe.baseWe = baseWrEn & ~busy;
  end

endmodule

// File: rtl/pt_xlate_dpath.sv
module pt_xlate_dpath
  import pt_xlate_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int DEPTH = 64
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobeS              strobe,
  input  logic [VA_W-1:0]         reqVaddr,
  input  logic                    reqWrite,
  input  logic                    reqUser,
  input  logic [$clog2(DEPTH)-1:0] tblWrIdx,
  input  logic [PA_W-OFF_W+3:0]   tblWrData,
  input  logic [$clog2(DEPTH)-1:0] baseWrData,
  output logic                    rspValid,
  output logic [PA_W-1:0]         rspPaddr,
  output logic                    rspFault,
  output logic [1:0]              rspKind
);

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SUM_W = ((VPN_W > IDX_W) ? VPN_W : IDX_W) + 1;
  localparam int ENT_W = PPN_W + 4;
  localparam int B_VAL = PPN_W + 3;
  localparam int B_USR = PPN_W + 2;
  localparam int B_RD  = PPN_W + 1;
  localparam int B_WR  = PPN_W;

  logic [ENT_W-1:0] tbl [DEPTH];
  logic [IDX_W-1:0] baseQ;

  logic [SUM_W-1:0] slotSum;
  logic             inRange;
  logic [ENT_W-1:0] entRd;

  logic [ENT_W-1:0] entQ;
  logic             inRangeQ;
  logic [OFF_W-1:0] offQ;
  logic             wrQ;
  logic             userQ;
  logic             validQ;

  always_comb begin
    slotSum = SUM_W'(reqVaddr[VA_W-1:OFF_W]) + SUM_W'(baseQ);
    inRange = slotSum < SUM_W'(DEPTH);
    entRd   = tbl[slotSum[IDX_W-1:0]];
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : gSlot
      always_ff @(posedge clk) begin
        if (!rstN) begin
          tbl[g] <= '0;
        end else if (strobe.tblWe && (tblWrIdx == IDX_W'(g))) begin
          tbl[g] <= tblWrData;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
    end else if (strobe.baseWe) begin
      baseQ <= baseWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ   <= 1'b0;
      entQ     <= '0;
      inRangeQ <= 1'b0;
      offQ     <= '0;
      wrQ      <= 1'b0;
      userQ    <= 1'b0;
    end else begin
      validQ <= strobe.lookup;
      if (strobe.lookup) begin
        entQ     <= entRd;
        inRangeQ <= inRange;
        offQ     <= reqVaddr[OFF_W-1:0];
        wrQ      <= reqWrite;
        userQ    <= reqUser;
      end
    end
  end

  faultKindE kind;
  logic      permOk;

  always_comb begin
    permOk = (wrQ ? entQ[B_WR] : entQ[B_RD]) & (~userQ | entQ[B_USR]);
    if (!inRangeQ || !entQ[B_VAL]) begin
      kind = KIND_PAGE;
    end else if (!permOk) begin
      kind = KIND_PROT;
    end else begin
      kind = KIND_NONE;
    end
    rspValid = validQ;
    rspKind  = validQ ? kind : KIND_NONE;
    rspFault = validQ && (kind != KIND_NONE);
    rspPaddr = (validQ && kind == KIND_NONE) ? {entQ[PPN_W-1:0], offQ} : '0;
  end

endmodule

// File: rtl/pt_xlate.sv
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  input  logic [VA_W-1:0]          reqVaddr,
  input  logic                     reqWrite,
  input  logic                     reqUser,
  output logic                     rspValid,
  output logic [PA_W-1:0]          rspPaddr,
  output logic                     rspFault,
  output logic [1:0]               rspKind,
  input  logic                     tblWrEn,
  input  logic [$clog2(DEPTH)-1:0] tblWrIdx,
  input  logic [PA_W-OFF_W+3:0]    tblWrData,
  input  logic                     baseWrEn,
  input  logic [$clog2(DEPTH)-1:0] baseWrData
);

  ctrlStrobeS strobe;

  pt_xlate_ctrl ctrl_i (
    .reqValid (reqValid),
    .rspPend  (rspValid),
    .tblWrEn  (tblWrEn),
    .baseWrEn (baseWrEn),
    .strobe   (strobe)
  );

  pt_xlate_dpath #(
    .VA_W (VA_W), .PA_W (PA_W), .OFF_W (OFF_W), .DEPTH (DEPTH)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .reqUser    (reqUser),
    .tblWrIdx   (tblWrIdx),
    .tblWrData  (tblWrData),
    .baseWrData (baseWrData),
    .rspValid   (rspValid),
    .rspPaddr   (rspPaddr),
    .rspFault   (rspFault),
    .rspKind    (rspKind)
  );

endmodule

// File: rtl/pt_xlate_chk.sv
module pt_xlate_chk #(
  parameter int VA_W  = 14,
  parameter int PA_W  = 12,
  parameter int OFF_W = 6
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic [VA_W-1:0] reqVaddr,
  input logic            rspValid,
  input logic [PA_W-1:0] rspPaddr,
  input logic            rspFault,
  input logic [1:0]      rspKind
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid); // R1

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid); // R1

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspFault) |-> rspPaddr[OFF_W-1:0] == $past(reqVaddr[OFF_W-1:0])); // R2

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspPaddr == '0) && rspValid); // R4

  AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    rspFault |-> (rspKind == 2'd1 || rspKind == 2'd2)); // R5

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspFault && rspKind == 2'd0); // R9

endmodule

bind pt_xlate pt_xlate_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqVaddr (reqVaddr),
  .rspValid (rspValid),
  .rspPaddr (rspPaddr),
  .rspFault (rspFault),
  .rspKind  (rspKind)
);

// File: tb/pt_xlate_tb_top.sv
module pt_xlate_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [13:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        rspValid;
  logic [11:0] rspPaddr;
  logic        rspFault;
  logic [1:0]  rspKind;
  logic        tblWrEn = 1'b0;
  logic [5:0]  tblWrIdx = '0;
  logic [9:0]  tblWrData = '0;
  logic        baseWrEn = 1'b0;
  logic [5:0]  baseWrData = '0;

  int vecCnt = 0;
  int badCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pt_xlate dut_i (.*);

  // vector: {vaddr[13:0], write, user, kind[1:0], paddr[11:0]}
  localparam int NV = 14;
  localparam logic [29:0] VEC [NV] = '{
    {14'h0015, 1'b0, 1'b1, 2'd0, 12'hA15},  // R2 user read ok
    {14'h003F, 1'b1, 1'b0, 2'd0, 12'hA3F},  // R2 kernel write ok
    {14'h0040, 1'b0, 1'b0, 2'd1, 12'h000},  // R4 invalid slot
    {14'h0040, 1'b1, 1'b1, 2'd1, 12'h000},  // R7 page beats prot
    {14'h0081, 1'b0, 1'b1, 2'd2, 12'h000},  // R5 kernel-only page
    {14'h00A2, 1'b1, 1'b0, 2'd0, 12'hCE2},  // R5 kernel allowed
    {14'h00C7, 1'b0, 1'b1, 2'd0, 12'h087},  // R6 read-only read
    {14'h00C7, 1'b1, 1'b0, 2'd2, 12'h000},  // R6 read-only write
    {14'h0109, 1'b0, 1'b1, 2'd2, 12'h000},  // R6 write-only read
    {14'h0109, 1'b1, 1'b1, 2'd0, 12'h589},  // R6 write-only write
    {14'h0EEA, 1'b0, 1'b1, 2'd0, 12'hFEA},  // R3 last slot
    {14'h0F00, 1'b0, 1'b0, 2'd1, 12'h000},  // R4 past table end
    {14'h3FFF, 1'b1, 1'b0, 2'd1, 12'h000},  // R4 top page
    {14'h0140, 1'b0, 1'b0, 2'd1, 12'h000}   // R9 never written slot
  };

  task automatic check(input string req, input logic v, input logic [1:0] k,
                       input logic [11:0] pa);
    vecCnt++;
    if (rspValid !== v || rspKind !== k || rspFault !== (k != 2'd0) ||
        rspPaddr !== pa) begin
      badCnt++;
      $display("FAIL %s: got v=%0b kind=%0d fault=%0b pa=%h, want v=%0b kind=%0d pa=%h",
               req, rspValid, rspKind, rspFault, rspPaddr, v, k, pa);
    end
  endtask

  task automatic wrSlot(input logic [5:0] idx, input logic [9:0] data);
    @(negedge clk);
    tblWrEn = 1'b1; tblWrIdx = idx; tblWrData = data;
    @(negedge clk);
    tblWrEn = 1'b0;
  endtask

  task automatic wrBase(input logic [5:0] b);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = b;
    @(negedge clk);
    baseWrEn = 1'b0;
  endtask

  task automatic lookup(input logic [13:0] va, input logic w, input logic u);
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = va; reqWrite = w; reqUser = u;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, badCnt);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    badCnt++;
    $display("FAIL watchdog: got timeout, want completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset", 1'b0, 2'd0, 12'h000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 idle", 1'b0, 2'd0, 12'h000);

    // R9: empty table, base 0 -> vpn 0 faults
    lookup(14'h0015, 1'b0, 1'b0);
    check("R9 empty table", 1'b1, 2'd1, 12'h000);
    @(negedge clk);
    check("R1 single response", 1'b0, 2'd0, 12'h000);

    // R3 layout: base 4; slot = {valid,user,read,write,ppn}
    wrBase(6'd4);
    wrSlot(6'd4,  10'h3E8);
    wrSlot(6'd5,  10'h011);
    wrSlot(6'd6,  10'h2F3);
    wrSlot(6'd7,  10'h382);
    wrSlot(6'd8,  10'h356);
    wrSlot(6'd63, 10'h3FF);

    // back-to-back vector walk (R1)
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      reqValid = 1'b1;
      {reqVaddr, reqWrite, reqUser} = VEC[i][29:14];
      @(negedge clk);
      check($sformatf("R1 vector %0d", i), 1'b1, VEC[i][13:12], VEC[i][11:0]);
    end
    reqValid = 1'b0;
    @(negedge clk);
    check("R1 stream end", 1'b0, 2'd0, 12'h000);

    // R8: slot write during a request cycle is dropped
    reqValid = 1'b1; reqVaddr = 14'h0015; reqWrite = 1'b0; reqUser = 1'b1;
    tblWrEn = 1'b1; tblWrIdx = 6'd4; tblWrData = 10'h000;
    @(negedge clk);
    reqValid = 1'b0;
    check("R8 request beside write", 1'b1, 2'd0, 12'hA15);
    // still asserted during the response cycle: dropped too
    baseWrEn = 1'b1; baseWrData = 6'd0;
    @(negedge clk);
    tblWrEn = 1'b0; baseWrEn = 1'b0;
    lookup(14'h0015, 1'b0, 1'b1);
    check("R8 slot and base unchanged", 1'b1, 2'd0, 12'hA15);

    // R3: move base to 0, vpn 4 now reaches slot 4
    wrBase(6'd0);
    lookup(14'h0109, 1'b1, 1'b1);
    check("R3 base moved", 1'b1, 2'd0, 12'hA09);
    // R3: vpn 63 with base 0 reaches slot 63
    lookup(14'h0FC1, 1'b0, 1'b0);
    check("R3 top slot base 0", 1'b1, 2'd0, 12'hFC1);

    // R9: reset again wipes table and base
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    lookup(14'h0109, 1'b0, 1'b0);
    check("R9 table wiped", 1'b1, 2'd1, 12'h000);

    finishRun();
  end

endmodule